// File: doc/BRIEF.md
# Single-Frame Network Port

This block is a memory-mapped network port that holds exactly one received frame and one outgoing frame in byte buffers. A host reaches it over a small register bus (byte offsets taken from the low six address bits, separate read and write strobes, 32-bit data). Frames move one byte per register access: the host pulls received bytes from a receive data port and pushes outgoing bytes into a transmit data port.

On the network side a byte stream with start, end and valid markers fills the receive buffer whenever the port is idle, and a byte stream with valid and last carries each outgoing frame out as soon as the host has written its final byte. An event register with transmit-done, receive-done and a self-test flag drives one level interrupt. While any event flag is pending the port reports busy and refuses new frames, so the host must acknowledge an event before the next frame can land.

Top module: `frame_port_nic`

## Requirements
- R1: After reset, busy reads 1, both byte counts and the event register read 0, `irq`, `rx_ready` and `tx_valid` are low and `host_rdata` is 0.
- R2: Only `host_addr[5:0]` is decoded. Offset 0x00 reads 0x4D495053 and offset 0x04 reads 0x4E455430; offsets 0x18, 0x20 and every unmapped offset read 0. Read data appears on `host_rdata` in the cycle after `host_rd`.
- R3: A write to the transmit count (offset 0x10) stores the value if it is at most MAX_LEN and stores 0 otherwise, and resets the transmit write pointer; it is ignored while a frame is being sent.
- R4: Each write to the transmit data port (offset 0x20) stores `host_wdata[7:0]` and advances the write pointer; when the pointer reaches the count the frame is sent, the count returns to 0, transmit-done (event bit 0) and busy are set. Data-port writes while the count is 0 are ignored.
- R5: A sent frame appears on `tx_data` with `tx_valid` high for one cycle per byte, in write order, starting the cycle after the final data-port write, with `tx_last` on the final byte only.
- R6: `rx_ready` is high while a frame is being captured, or while busy is 0 and the receive count is below MAX_LEN. Only a beat with `rx_sof` starts a frame; beats outside a frame are dropped.
- R7: The beat with `rx_eof` ends the frame: the receive count (offset 0x0C) takes the frame length, the read pointer returns to the first byte, receive-done (event bit 1) and busy are set.
- R8: Bytes beyond MAX_LEN in one frame are dropped and the stored length is MAX_LEN.
- R9: A read of the receive data port (offset 0x1C) while the receive count is nonzero returns the next byte in arrival order and decrements the count; with the count at 0 it returns 0 and changes nothing.
- R10: A write to the event register (offset 0x14) acts on one bit only, by priority: bit 0 clears transmit-done, else bit 1 clears receive-done, else bit 31 performs a soft reset; a zero write changes no flag. Busy then becomes 1 exactly when any flag remains set.
- R11: A soft reset clears both counts and pointers, aborts any frame in flight and sets the self-test flag (event bit 31). A read of the event register returns its value and then clears the self-test flag, leaving busy unchanged.
- R12: `irq` is high exactly while any event flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register byte address, low six bits decoded |
| host_wr | input | 1 | Write strobe, wins over a read in the same cycle |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Receive beat valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Port accepts the beat |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
Register reads land in `host_rdata` at the edge that samples `host_rd`, so the bench drives each access on a falling edge and reads the result on the following falling edge. Flag, count and busy changes caused by a write or by the end-of-frame beat take effect at that same edge and are observed through a later read or directly on `irq` and `rx_ready` half a cycle after it. The first transmit byte is on the stream at the falling edge right after the final data-port write, and each later byte one cycle after the one before, which the bench samples on consecutive falling edges.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  // register byte offsets after masking to six bits
  localparam logic [5:0] OFF_ID_HI   = 6'h00;
  localparam logic [5:0] OFF_ID_LO   = 6'h04;
  localparam logic [5:0] OFF_BUSY    = 6'h08;
  localparam logic [5:0] OFF_RXCNT   = 6'h0C;
  localparam logic [5:0] OFF_TXCNT   = 6'h10;
  localparam logic [5:0] OFF_EVT     = 6'h14;
  localparam logic [5:0] OFF_EVTINFO = 6'h18;
  localparam logic [5:0] OFF_RXPORT  = 6'h1C;
  localparam logic [5:0] OFF_TXPORT  = 6'h20;

  localparam logic [31:0] ID_WORD_HI = 32'h4D49_5053;
  localparam logic [31:0] ID_WORD_LO = 32'h4E45_5430;

  localparam int BIT_TXDONE = 0;
  localparam int BIT_RXDONE = 1;
  localparam int BIT_TEST   = 31;

  typedef struct packed {
    logic test;
    logic rx_done;
    logic tx_done;
  } evt_flags_t;

  function automatic logic [31:0] flags_to_word(evt_flags_t f);
    logic [31:0] w;
    w = '0;
    w[BIT_TEST]   = f.test;
    w[BIT_RXDONE] = f.rx_done;
    w[BIT_TXDONE] = f.tx_done;
    return w;
  endfunction

endpackage

// File: rtl/fpn_byte_ram.sv
module fpn_byte_ram #(
  parameter int DEPTH = 1514,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fpn_rx_capture.sv
module fpn_rx_capture #(
  parameter int MAX_LEN = 1514,
  parameter int CNT_W   = $clog2(MAX_LEN + 1),
  parameter int AW      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             can_start,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             done,
  output logic [CNT_W-1:0] done_len,
  output logic             active
);

  logic             act_q, act_d;
  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic             beat, room;

  assign in_ready  = act_q | can_start;
  assign beat      = in_valid & in_ready;
  assign room      = ptr_q < CNT_W'(MAX_LEN);
  assign mem_wdata = in_data;
  assign active    = act_q;

  always_comb begin
    act_d    = act_q;
    ptr_d    = ptr_q;
    mem_we   = 1'b0;
    mem_addr = AW'(ptr_q);
    done     = 1'b0;
    done_len = ptr_q;
    if (abort) begin
      act_d = 1'b0;
      ptr_d = '0;
    end else if (beat && (in_sof || act_q)) begin
      if (in_sof) begin
        mem_we   = 1'b1;
        mem_addr = '0;
        ptr_d    = CNT_W'(1);
      end else if (room) begin
        mem_we = 1'b1;
        ptr_d  = ptr_q + 1'b1;
      end
      act_d = ~in_eof;
      if (in_eof) begin
        done     = 1'b1;
        done_len = ptr_d;
        ptr_d    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      act_q <= act_d;
      ptr_q <= ptr_d;
    end
  end

  AST_RXPTR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= CNT_W'(MAX_LEN)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !act_q); // R7

endmodule

// File: rtl/fpn_tx_emit.sv
module fpn_tx_emit #(
  parameter int MAX_LEN = 1514,
  parameter int CNT_W   = $clog2(MAX_LEN + 1),
  parameter int AW      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [CNT_W-1:0] start_len,
  output logic             out_valid,
  output logic             out_last,
  output logic [AW-1:0]    mem_raddr,
  output logic             active
);

  logic             act_q, act_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] len_q, len_d;

  assign out_valid = act_q;
  assign out_last  = act_q && (idx_q == CNT_W'(len_q - 1'b1));
  assign mem_raddr = AW'(idx_q);
  assign active    = act_q;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    len_d = len_q;
    if (abort) begin
      act_d = 1'b0;
      idx_d = '0;
    end else if (start) begin
      act_d = 1'b1;
      idx_d = '0;
      len_d = start_len;
    end else if (act_q) begin
      if (out_last) act_d = 1'b0;
      else          idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      len_q <= len_d;
    end
  end

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && !start) |=> !out_valid); // R5
  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (idx_q < len_q)); // R5

endmodule

// File: rtl/frame_port_nic.sv
module frame_port_nic #(
  parameter int ADDR_W  = 8,
  parameter int MAX_LEN = 1514
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last
);
  import fpn_pkg::*;

  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int AW    = $clog2(MAX_LEN);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [5:0]       off;
  logic             wr_acc, rd_acc, soft_rst;
  logic             busy_q, busy_d;
  evt_flags_t       flags_q, flags_d;
  logic [CNT_W-1:0] rx_cnt_q, rx_cnt_d, rx_rp_q, rx_rp_d;
  logic [CNT_W-1:0] tx_cnt_q, tx_cnt_d, tx_wp_q, tx_wp_d;
  logic [31:0]      rdata_q, rdata_d;
  logic             tx_start, txbuf_we, tx_active;
  logic             rx_we, rx_done, rx_active;
  logic [AW-1:0]    rx_waddr, tx_raddr;
  logic [7:0]       rx_wbyte, rx_rbyte;
  logic [CNT_W-1:0] rx_len;

  assign off      = host_addr[5:0];
  assign wr_acc   = host_wr;
  assign rd_acc   = host_rd & ~host_wr;
  assign soft_rst = wr_acc && (off == OFF_EVT) && !host_wdata[BIT_TXDONE]
                    && !host_wdata[BIT_RXDONE] && host_wdata[BIT_TEST];

  fpn_rx_capture #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .AW(AW)) u_rx (
    .clk(clk), .rst_n(rst_ni), .abort(soft_rst),
    .can_start(!busy_q && (rx_cnt_q < CNT_W'(MAX_LEN))),
    .in_valid(rx_valid), .in_sof(rx_sof), .in_eof(rx_eof), .in_data(rx_data),
    .in_ready(rx_ready), .mem_we(rx_we), .mem_addr(rx_waddr), .mem_wdata(rx_wbyte),
    .done(rx_done), .done_len(rx_len), .active(rx_active)
  );

  fpn_byte_ram #(.DEPTH(MAX_LEN), .AW(AW)) u_rx_ram (
    .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wbyte),
    .raddr(AW'(rx_rp_q)), .rdata(rx_rbyte)
  );

  fpn_byte_ram #(.DEPTH(MAX_LEN), .AW(AW)) u_tx_ram (
    .clk(clk), .we(txbuf_we), .waddr(AW'(tx_wp_q)), .wdata(host_wdata[7:0]),
    .raddr(tx_raddr), .rdata(tx_data)
  );

  fpn_tx_emit #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .AW(AW)) u_tx (
    .clk(clk), .rst_n(rst_ni), .abort(soft_rst), .start(tx_start),
    .start_len(tx_cnt_q), .out_valid(tx_valid), .out_last(tx_last),
    .mem_raddr(tx_raddr), .active(tx_active)
  );

  always_comb begin
    busy_d   = busy_q;
    flags_d  = flags_q;
    rx_cnt_d = rx_cnt_q;
    rx_rp_d  = rx_rp_q;
    tx_cnt_d = tx_cnt_q;
    tx_wp_d  = tx_wp_q;
    rdata_d  = rdata_q;
    tx_start = 1'b0;
    txbuf_we = 1'b0;
    if (wr_acc) begin
      case (off)
        OFF_TXCNT: if (!tx_active) begin
          tx_cnt_d = (host_wdata <= 32'(MAX_LEN)) ? host_wdata[CNT_W-1:0] : '0;
          tx_wp_d  = '0;
        end
        OFF_EVT: begin
          if (host_wdata[BIT_TXDONE])      flags_d.tx_done = 1'b0;
          else if (host_wdata[BIT_RXDONE]) flags_d.rx_done = 1'b0;
          else if (host_wdata[BIT_TEST]) begin
            rx_cnt_d = '0;
            rx_rp_d  = '0;
            tx_cnt_d = '0;
            tx_wp_d  = '0;
            flags_d  = '{test: 1'b1, rx_done: 1'b0, tx_done: 1'b0};
          end
          busy_d = |flags_d;
        end
        OFF_TXPORT: if (tx_cnt_q != '0) begin
          txbuf_we = 1'b1;
          tx_wp_d  = tx_wp_q + 1'b1;
          if (CNT_W'(tx_wp_q + 1'b1) == tx_cnt_q) begin
            tx_start        = 1'b1;
            tx_cnt_d        = '0;
            tx_wp_d         = '0;
            flags_d.tx_done = 1'b1;
            busy_d          = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (rd_acc) begin
      case (off)
        OFF_ID_HI: rdata_d = ID_WORD_HI;
        OFF_ID_LO: rdata_d = ID_WORD_LO;
        OFF_BUSY:  rdata_d = {31'b0, busy_q};
        OFF_RXCNT: rdata_d = 32'(rx_cnt_q);
        OFF_TXCNT: rdata_d = 32'(tx_cnt_q);
        OFF_EVT: begin
          rdata_d      = flags_to_word(flags_q);
          flags_d.test = 1'b0;
        end
        OFF_RXPORT: begin
          rdata_d = '0;
          if (rx_cnt_q != '0) begin
            rdata_d  = {24'b0, rx_rbyte};
            rx_cnt_d = rx_cnt_q - 1'b1;
            rx_rp_d  = rx_rp_q + 1'b1;
          end
        end
        OFF_EVTINFO, OFF_TXPORT: rdata_d = '0;
        default:                 rdata_d = '0;
      endcase
    end
    if (rx_done && !soft_rst) begin
      rx_cnt_d        = rx_len;
      rx_rp_d         = '0;
      flags_d.rx_done = 1'b1;
      busy_d          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b1;
      flags_q  <= '0;
      rx_cnt_q <= '0;
      rx_rp_q  <= '0;
      tx_cnt_q <= '0;
      tx_wp_q  <= '0;
      rdata_q  <= '0;
    end else begin
      busy_q   <= busy_d;
      flags_q  <= flags_d;
      rx_cnt_q <= rx_cnt_d;
      rx_rp_q  <= rx_rp_d;
      tx_cnt_q <= tx_cnt_d;
      tx_wp_q  <= tx_wp_d;
      rdata_q  <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = |flags_q;

  AST_RXCNT_CAP: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_cnt_q <= CNT_W'(MAX_LEN)); // R8
  AST_TXCNT_CAP: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_cnt_q <= CNT_W'(MAX_LEN)); // R3
  AST_TXPTR_BELOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_cnt_q != '0) |-> (tx_wp_q < tx_cnt_q)); // R4
  AST_TEST_RDCLR: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_acc && off == OFF_EVT) |=> !flags_q.test); // R11
  AST_RXDONE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flags_q.rx_done) |-> busy_q); // R7
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && !rx_active) |-> !rx_ready); // R6

endmodule

// File: tb/sim_frame_port_nic.sv
module sim_frame_port_nic;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 1514;
  localparam logic [7:0] A_BUSY = 8'h08, A_RXCNT = 8'h0C, A_TXCNT = 8'h10,
                         A_EVT = 8'h14, A_RXP = 8'h1C, A_TXP = 8'h20;

  // {address, expected read value}
  localparam logic [39:0] RD_VEC [8] = '{
    {8'h00, 32'h4D495053}, {8'h04, 32'h4E455430}, {8'h18, 32'h0},
    {8'h20, 32'h0},        {8'h24, 32'h0},        {8'h3C, 32'h0},
    {8'h40, 32'h4D495053}, {8'h84, 32'h4E455430}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  host_addr;
  logic        host_wr, host_rd;
  logic [31:0] host_wdata, host_rdata;
  logic        irq, rx_valid, rx_sof, rx_eof, rx_ready, tx_valid, tx_last;
  logic [7:0]  rx_data, tx_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_port_nic #(.ADDR_W(8), .MAX_LEN(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] rd_val;
  bit          done_flag = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    rd_val = host_rdata;
  endtask

  task automatic send_rx(int len, logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = seed + 8'(i);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  function automatic logic [31:0] txw();
    return {22'b0, tx_valid, tx_last, tx_data};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int errs;
    rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 rx_ready in reset", 32'(rx_ready), 32'd0);
    chk("R1 tx_valid in reset", 32'(tx_valid), 32'd0);
    chk("R1 irq in reset", 32'(irq), 32'd0);
    chk("R1 rdata in reset", host_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(A_BUSY);  chk("R1 busy", rd_val, 32'd1);
    bus_rd(A_RXCNT); chk("R1 rx count", rd_val, 32'd0);
    bus_rd(A_TXCNT); chk("R1 tx count", rd_val, 32'd0);
    bus_rd(A_EVT);   chk("R1 events", rd_val, 32'd0);
    chk("R1 R6 rx_ready while busy", 32'(rx_ready), 32'd0);

    for (int k = 0; k < 8; k++) begin
      bus_rd(RD_VEC[k][39:32]);
      chk($sformatf("R2 read 0x%h", RD_VEC[k][39:32]), rd_val, RD_VEC[k][31:0]);
    end

    bus_wr(A_EVT, 32'd0);
    bus_rd(A_BUSY); chk("R10 busy after zero write", rd_val, 32'd0);
    chk("R6 ready when idle", 32'(rx_ready), 32'd1);

    // transmit count limit and a three-byte frame
    bus_wr(A_TXCNT, 32'd2000);
    bus_rd(A_TXCNT); chk("R3 oversize count", rd_val, 32'd0);
    bus_wr(A_TXCNT, 32'd3);
    bus_wr(A_TXP, 32'hA1); bus_wr(A_TXP, 32'hB2); bus_wr(A_TXP, 32'hC3);
    chk("R5 byte0", txw(), {22'b0, 1'b1, 1'b0, 8'hA1});
    @(negedge clk); chk("R5 byte1", txw(), {22'b0, 1'b1, 1'b0, 8'hB2});
    @(negedge clk); chk("R5 byte2 last", txw(), {22'b0, 1'b1, 1'b1, 8'hC3});
    @(negedge clk); chk("R5 stream ends", 32'(tx_valid), 32'd0);
    bus_rd(A_EVT);   chk("R4 tx done flag", rd_val, 32'd1);
    chk("R12 irq with tx done", 32'(irq), 32'd1);
    bus_rd(A_BUSY);  chk("R4 busy after send", rd_val, 32'd1);
    bus_rd(A_TXCNT); chk("R4 count back to zero", rd_val, 32'd0);
    bus_wr(A_EVT, 32'd1);
    bus_rd(A_EVT);   chk("R10 clear tx done", rd_val, 32'd0);
    chk("R12 irq low", 32'(irq), 32'd0);

    // count write during emission is ignored
    bus_wr(A_TXCNT, 32'd4);
    for (int i = 0; i < 4; i++) bus_wr(A_TXP, 32'(i));
    bus_wr(A_TXCNT, 32'd5);
    repeat (4) @(negedge clk);
    bus_rd(A_TXCNT); chk("R3 count write ignored while sending", rd_val, 32'd0);
    bus_wr(A_EVT, 32'd1);
    bus_wr(A_TXP, 32'h55);
    chk("R4 data write with zero count no stream", 32'(tx_valid), 32'd0);
    bus_rd(A_EVT); chk("R4 data write with zero count no flag", rd_val, 32'd0);

    // five-byte receive frame
    chk("R6 ready before frame", 32'(rx_ready), 32'd1);
    send_rx(5, 8'h10);
    chk("R6 ready low after frame", 32'(rx_ready), 32'd0);
    bus_rd(A_RXCNT); chk("R7 rx count", rd_val, 32'd5);
    bus_rd(A_EVT);   chk("R7 rx done flag", rd_val, 32'd2);
    bus_rd(A_BUSY);  chk("R7 busy", rd_val, 32'd1);
    bus_rd(A_RXP);   chk("R9 byte0", rd_val, 32'h10);
    bus_rd(A_RXP);   chk("R9 byte1", rd_val, 32'h11);
    bus_rd(A_RXCNT); chk("R9 count decrements", rd_val, 32'd3);

    bus_wr(A_TXCNT, 32'd1);
    bus_wr(A_TXP, 32'h77);
    chk("R5 single byte frame", txw(), {22'b0, 1'b1, 1'b1, 8'h77});
    bus_rd(A_EVT);  chk("R4 both flags", rd_val, 32'd3);
    bus_wr(A_EVT, 32'd3);
    bus_rd(A_EVT);  chk("R10 bit0 wins over bit1", rd_val, 32'd2);
    bus_rd(A_BUSY); chk("R10 busy with flag left", rd_val, 32'd1);
    bus_wr(A_EVT, 32'h8000_0002);
    bus_rd(A_EVT);   chk("R10 bit1 wins over bit31", rd_val, 32'd0);
    bus_rd(A_RXCNT); chk("R11 no soft reset taken", rd_val, 32'd3);
    bus_rd(A_BUSY);  chk("R10 busy cleared", rd_val, 32'd0);
    bus_rd(A_RXP);   chk("R9 byte2", rd_val, 32'h12);
    bus_rd(A_RXP);   chk("R9 byte3", rd_val, 32'h13);
    bus_rd(A_RXP);   chk("R9 byte4", rd_val, 32'h14);
    bus_rd(A_RXP);   chk("R9 empty read", rd_val, 32'd0);
    bus_rd(A_RXCNT); chk("R9 count stays zero", rd_val, 32'd0);

    // stray beat outside a frame
    @(negedge clk); rx_valid = 1'b1; rx_eof = 1'b1; rx_data = 8'h99;
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    bus_rd(A_RXCNT); chk("R6 stray beat dropped count", rd_val, 32'd0);
    bus_rd(A_EVT);   chk("R6 stray beat dropped flag", rd_val, 32'd0);

    // oversize frame
    send_rx(MAXB + 6, 8'h00);
    bus_rd(A_RXCNT); chk("R8 truncated length", rd_val, 32'(MAXB));
    bus_wr(A_EVT, 32'd2);
    chk("R6 ready low with full buffer", 32'(rx_ready), 32'd0);
    errs = 0;
    for (int j = 0; j < MAXB; j++) begin
      bus_rd(A_RXP);
      if (rd_val !== 32'(j & 8'hFF)) errs++;
    end
    chk("R8 truncated content", 32'(errs), 32'd0);
    bus_rd(A_RXCNT); chk("R9 drained", rd_val, 32'd0);
    chk("R6 ready after drain", 32'(rx_ready), 32'd1);

    // soft reset
    bus_wr(A_TXCNT, 32'd7);
    send_rx(2, 8'h40);
    bus_rd(A_RXCNT); chk("R7 short frame", rd_val, 32'd2);
    bus_wr(A_EVT, 32'h8000_0000);
    chk("R12 irq with test flag", 32'(irq), 32'd1);
    bus_rd(A_TXCNT); chk("R11 tx count cleared", rd_val, 32'd0);
    bus_rd(A_RXCNT); chk("R11 rx count cleared", rd_val, 32'd0);
    bus_rd(A_RXP);   chk("R11 rx port empty", rd_val, 32'd0);
    bus_rd(A_EVT);   chk("R11 test flag read", rd_val, 32'h8000_0000);
    chk("R12 irq after read clear", 32'(irq), 32'd0);
    bus_rd(A_BUSY);  chk("R11 busy kept by read", rd_val, 32'd1);
    bus_rd(A_EVT);   chk("R11 test flag cleared", rd_val, 32'd0);
    bus_wr(A_EVT, 32'd0);
    bus_rd(A_BUSY);  chk("R10 zero write releases busy", rd_val, 32'd0);

    bus_wr(A_EVT, 32'h8000_0000);
    bus_wr(A_EVT, 32'd0);
    bus_rd(A_BUSY); chk("R10 zero write keeps busy", rd_val, 32'd1);
    bus_rd(A_EVT);  chk("R10 zero write keeps test flag", rd_val, 32'h8000_0000);

    done_flag = 1;
    finish_run();
  end

endmodule